// File: doc/BRIEF.md
# Sort-Free Capacitor Voltage Balancer

This block decides which submodules of one converter valve are switched in. Each cycle it compares the number of submodules that are ON with a commanded ON-count. When they differ it switches exactly one submodule, either ON or OFF. The submodule is the one whose capacitor voltage is highest or lowest among those currently in the opposite state. The sign of the valve current decides which: a charging current (strictly positive) inserts the weakest capacitor and removes the strongest. A zero or discharging current does the reverse. No sorting takes place. Four single-extremum searches run over voltages masked by the present gating state.

When enable rises, the gating vector starts from a simple pattern: the lowest-indexed submodules are ON, as many as the reference asks for. While enable is low the vector is frozen. An idle timer, programmable and disabled by a limit of zero, counts cycles in which nothing switched. When the count matches the reference and the timer has expired, it swaps one OFF submodule in and one ON submodule out.

Top module: `vbal_top`

## Requirements
- R1: On the first enabled cycle after enable was low (or after reset), the gating vector becomes ON for indices 0 .. ref-1 and OFF for all others.
- R2: When the ON-count is below the reference and the current is strictly positive, the OFF submodule with the lowest voltage turns ON and nothing else changes.
- R3: When the ON-count is below the reference and the current is zero or negative, the OFF submodule with the highest voltage turns ON and nothing else changes.
- R4: When the ON-count is above the reference and the current is strictly positive, the ON submodule with the highest voltage turns OFF and nothing else changes.
- R5: When the ON-count is above the reference and the current is zero or negative, the ON submodule with the lowest voltage turns OFF and nothing else changes.
- R6: When the ON-count equals the reference and the idle timer has not expired, the gating vector is unchanged.
- R7: An idle counter clears on the first enabled cycle and on any cycle that switches, and otherwise counts balanced cycles, saturating at its maximum. With a nonzero limit L, on a balanced cycle with counter >= L, the lowest-voltage OFF submodule turns ON and the highest-voltage ON submodule turns OFF in the same cycle, provided both exist. The ON-count is unchanged.
- R8: A watchdog limit of zero disables the forced swap entirely.
- R9: A submodule in the excluded state is never selected, and among equal voltages the lowest index is selected.
- R10: While enable is low the gating vector and idle counter hold, whatever the other inputs do.
- R11: Synchronous active-high reset clears the gating vector to all OFF.
- R12: A reference above the submodule count M is treated as M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Balancing enable; low freezes the gating state |
| n_ref | input | CW | Commanded ON-count (CW = clog2(M+1)) |
| i_valve | input | IW | Signed valve current, positive means charging |
| v_cap | input | M*VW | Capacitor voltages, submodule i at bits [i*VW +: VW] |
| wd_limit | input | WDW | Idle cycles before a forced swap; 0 disables |
| gate | output | M | Gating vector, bit i high means submodule i ON |

## Verification
The hardest case to reach is the forced swap. It needs a long run of balanced cycles with a nonzero limit, and then both an OFF and an ON submodule must exist. The bench holds the reference fixed at a mid value after convergence, with a small limit, so the swap recurs. It then repeats the run with a limit of zero to show the swap stays absent. Tie-breaking is reached by driving all voltages to one value, so every search has to fall back on the lowest eligible index.

// File: rtl/vbal_pkg.sv
package vbal_pkg;

    // Index width for submodule selection; supports up to 256 submodules.
    localparam int SM_IDX_W = 8;

    typedef struct packed {
        logic                found;
        logic [SM_IDX_W-1:0] idx;
    } sm_pick_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_RAISE,
        ACT_LOWER,
        ACT_SWAP
    } bal_act_e;

endpackage

// File: rtl/vbal_extremum.sv
module vbal_extremum
    import vbal_pkg::*;
#(
    parameter int N        = 8,
    parameter int VW       = 10,
    parameter bit FIND_MAX = 1'b0
) (
    input  logic [N*VW-1:0] v_all,
    input  logic [N-1:0]    ok,
    output sm_pick_t        res
);
    localparam int LV = (N < 2) ? 1 : $clog2(N);
    localparam int P  = 1 << LV;

    typedef struct packed {
        logic                ok;
        logic [VW-1:0]       v;
        logic [SM_IDX_W-1:0] idx;
    } cand_t;

    // Left operand carries the lower index, so ties keep it.
    function automatic cand_t better(input cand_t a, input cand_t b);
        if (!b.ok)      return a;
        if (!a.ok)      return b;
        if (FIND_MAX)   return (b.v > a.v) ? b : a;
        return (b.v < a.v) ? b : a;
    endfunction

    cand_t node [2*P-1];

    genvar gi;
    generate
        for (gi = 0; gi < P; gi++) begin : g_leaf
            if (gi < N) begin : g_real
                // Excluded submodules take the value that can never win.
                assign node[P-1+gi].ok  = ok[gi];
                assign node[P-1+gi].v   = ok[gi] ? v_all[gi*VW +: VW]
                                                 : (FIND_MAX ? '0 : '1);
                assign node[P-1+gi].idx = SM_IDX_W'(gi);
            end else begin : g_pad
                assign node[P-1+gi] = '{ok: 1'b0, v: '0, idx: '0};
            end
        end
        for (gi = 0; gi < P-1; gi++) begin : g_tree
            assign node[gi] = better(node[2*gi+1], node[2*gi+2]);
        end
    endgenerate

    assign res.found = node[0].ok;
    assign res.idx   = node[0].idx;
endmodule

// File: rtl/vbal_watchdog.sv
module vbal_watchdog #(
    parameter int WDW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           tick,
    input  logic [WDW-1:0] limit,
    output logic           fire
);
    logic [WDW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst)                         idle_q <= '0;
        else if (clear)                  idle_q <= '0;
        else if (tick && idle_q != '1)   idle_q <= idle_q + 1'b1;
    end

    assign fire = (limit != '0) && (idle_q >= limit);
endmodule

// File: rtl/vbal_top.sv
module vbal_top
    import vbal_pkg::*;
#(
    parameter int N   = 8,
    parameter int VW  = 10,
    parameter int IW  = 12,
    parameter int WDW = 8,
    localparam int CW = $clog2(N+1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CW-1:0]        n_ref,
    input  logic signed [IW-1:0] i_valve,
    input  logic [N*VW-1:0]      v_cap,
    input  logic [WDW-1:0]       wd_limit,
    output logic [N-1:0]         gate
);
    logic [N-1:0]  gate_q, gate_d, init_mask;
    logic          armed_q;
    logic [CW-1:0] cnt, refc;
    logic          charging, switched, wd_fire;
    bal_act_e      act;
    sm_pick_t      min_off, max_off, min_on, max_on, sel;

    assign refc     = (n_ref > CW'(N)) ? CW'(N) : n_ref;
    assign charging = (i_valve > 0);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) cnt = cnt + CW'(gate_q[i]);
    end

    always_comb begin
        for (int i = 0; i < N; i++) init_mask[i] = (CW'(i) < refc);
    end

    vbal_extremum #(.N(N), .VW(VW), .FIND_MAX(1'b0)) u_min_off (
        .v_all(v_cap), .ok(~gate_q), .res(min_off));
    vbal_extremum #(.N(N), .VW(VW), .FIND_MAX(1'b1)) u_max_off (
        .v_all(v_cap), .ok(~gate_q), .res(max_off));
    vbal_extremum #(.N(N), .VW(VW), .FIND_MAX(1'b0)) u_min_on (
        .v_all(v_cap), .ok(gate_q),  .res(min_on));
    vbal_extremum #(.N(N), .VW(VW), .FIND_MAX(1'b1)) u_max_on (
        .v_all(v_cap), .ok(gate_q),  .res(max_on));

    // Pick the action and the submodule the action applies to.
    always_comb begin
        act = ACT_HOLD;
        sel = '0;
        if (cnt < refc) begin
            sel = charging ? min_off : max_off;
            if (sel.found) act = ACT_RAISE;
        end else if (cnt > refc) begin
            sel = charging ? max_on : min_on;
            if (sel.found) act = ACT_LOWER;
        end else if (wd_fire && min_off.found && max_on.found) begin
            act = ACT_SWAP;
        end
    end

    assign switched = (act != ACT_HOLD);

    always_comb begin
        gate_d = gate_q;
        for (int i = 0; i < N; i++) begin
            unique case (act)
                ACT_RAISE: if (32'(sel.idx) == i) gate_d[i] = 1'b1;
                ACT_LOWER: if (32'(sel.idx) == i) gate_d[i] = 1'b0;
                ACT_SWAP: begin
                    if (32'(min_off.idx) == i) gate_d[i] = 1'b1;
                    if (32'(max_on.idx)  == i) gate_d[i] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    vbal_watchdog #(.WDW(WDW)) u_wd (
        .clk   (clk),
        .rst   (rst),
        .clear (en && (!armed_q || switched)),
        .tick  (en && armed_q),
        .limit (wd_limit),
        .fire  (wd_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= '0;
            armed_q <= 1'b0;
        end else if (!en) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            gate_q  <= armed_q ? gate_d : init_mask;
        end
    end

    assign gate = gate_q;
endmodule

// File: rtl/vbal_checker.sv
module vbal_checker #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [CW-1:0] n_ref,
    input logic [N-1:0]  gate,
    input logic          armed,
    input logic          wd_fire
);
    logic [CW-1:0] refc;
    int            cnt;
    assign refc = (n_ref > CW'(N)) ? CW'(N) : n_ref;
    assign cnt  = $countones(gate);

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> gate == '0);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(gate));

    // R1 and R12: initial pattern holds the clamped reference count
    a_r1_init_count: assert property (@(posedge clk) disable iff (rst)
        (en && !armed) |=> cnt == int'($past(refc)));

    // R2..R5: exactly one bit changes while unbalanced
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (en && armed && cnt != int'(refc)) |=> $countones(gate ^ $past(gate)) == 1);

    a_r6_quiet_when_balanced: assert property (@(posedge clk) disable iff (rst)
        (en && armed && cnt == int'(refc) && !wd_fire) |=> $stable(gate));

    a_r7_swap_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (en && armed && cnt == int'(refc)) |=> cnt == $past(cnt));
endmodule

bind vbal_top vbal_checker #(.N(N), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .n_ref   (n_ref),
    .gate    (gate),
    .armed   (armed_q),
    .wd_fire (wd_fire)
);

// File: tb/vbal_top_tb_top.sv
`timescale 1ns/1ps
module vbal_top_tb_top;
    localparam int N   = 8;
    localparam int VW  = 10;
    localparam int IW  = 12;
    localparam int WDW = 8;
    localparam int CW  = $clog2(N+1);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 en  = 1'b0;
    logic [CW-1:0]        n_ref = '0;
    logic signed [IW-1:0] i_valve = '0;
    logic [N*VW-1:0]      v_cap = '0;
    logic [WDW-1:0]       wd_limit = '0;
    logic [N-1:0]         gate;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [N-1:0] exp_gate = '0;
    bit           m_armed  = 0;
    int           m_idle   = 0;
    int           vv [N];
    int           cur = 0;
    string        phase = "";

    always #2.5 clk = ~clk;

    vbal_top #(.N(N), .VW(VW), .IW(IW), .WDW(WDW)) dut_i (
        .clk(clk), .rst(rst), .en(en), .n_ref(n_ref), .i_valve(i_valve),
        .v_cap(v_cap), .wd_limit(wd_limit), .gate(gate));

    function automatic int find(bit want_on, bit want_max);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (exp_gate[i] == want_on) begin
                if (best < 0) best = i;
                else if (want_max ? (vv[i] > vv[best]) : (vv[i] < vv[best])) best = i;
            end
        end
        return best;
    endfunction

    task automatic check(string tag, logic [N-1:0] act_v, logic [N-1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s%s gate=%b expected=%b", tag, phase, act_v, exp_v);
        end
    endtask

    // Apply inputs, advance the model one clock, compare after the edge.
    task automatic step(bit e, int r, int c, int lim);
        string tag;
        int    refc, on_cnt, k, a, b;
        bit    sw;
        en = e; n_ref = CW'(r); cur = c; i_valve = IW'(c); wd_limit = WDW'(lim);
        for (int i = 0; i < N; i++) v_cap[i*VW +: VW] = VW'(vv[i]);
        refc = (r > N) ? N : r;
        on_cnt = $countones(exp_gate);
        sw = 0;
        if (!e) begin
            tag = "R10"; m_armed = 0;
        end else if (!m_armed) begin
            tag = "R1";
            for (int i = 0; i < N; i++) exp_gate[i] = (i < refc);
            m_armed = 1; m_idle = 0;
        end else begin
            if (on_cnt < refc) begin
                tag = (c > 0) ? "R2" : "R3";
                k = find(0, !(c > 0)); exp_gate[k] = 1'b1; sw = 1;
            end else if (on_cnt > refc) begin
                tag = (c > 0) ? "R4" : "R5";
                k = find(1, (c > 0)); exp_gate[k] = 1'b0; sw = 1;
            end else begin
                tag = "R6";
                a = find(0, 0); b = find(1, 1);
                if (lim != 0 && m_idle >= lim && a >= 0 && b >= 0) begin
                    tag = "R7";
                    exp_gate[a] = 1'b1; exp_gate[b] = 1'b0; sw = 1;
                end
            end
            if (sw) m_idle = 0;
            else if (m_idle < (1 << WDW) - 1) m_idle++;
        end
        @(posedge clk); #1;
        check(tag, gate, exp_gate);
    endtask

    task automatic rand_volts();
        for (int i = 0; i < N; i++) vv[i] = $urandom_range(0, (1 << VW) - 1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) vv[i] = 100 + 7 * i;
        repeat (3) @(posedge clk);
        #1;
        check("R11", gate, '0);
        rst = 1'b0;

        // R10: disabled with active inputs
        phase = " hold";
        for (int s = 0; s < 4; s++) begin rand_volts(); step(0, 5, 40, 0); end

        // R1 then R6 settle
        phase = "";
        step(1, 3, 20, 0);
        for (int s = 0; s < 5; s++) begin rand_volts(); step(1, 3, -20, 0); end

        // R2..R5 under mixed references, currents and voltages
        for (int s = 0; s < 120; s++) begin
            rand_volts();
            step(1, $urandom_range(0, N), int'($urandom_range(0, 4)) - 2, 0);
        end

        // R9: all voltages equal, ties resolve to lowest index
        phase = " R9";
        for (int i = 0; i < N; i++) vv[i] = 300;
        for (int s = 0; s < 30; s++)
            step(1, $urandom_range(0, N), int'($urandom_range(0, 2)) - 1, 0);

        // R7: forced swap with a small limit
        phase = " R7";
        for (int s = 0; s < 30; s++) begin rand_volts(); step(1, 4, 10, 3); end

        // R8: limit zero never swaps
        phase = " R8";
        for (int s = 0; s < 20; s++) begin rand_volts(); step(1, 4, 10, 0); end

        // R12: reference above M
        phase = " R12";
        for (int s = 0; s < 12; s++) begin rand_volts(); step(1, 12, -5, 0); end

        // R10 then re-initialisation (R1)
        phase = " reinit";
        for (int s = 0; s < 3; s++) begin rand_volts(); step(0, 2, 5, 2); end
        step(1, 5, 5, 0);
        for (int s = 0; s < 6; s++) begin rand_volts(); step(1, 2, 5, 0); end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired before the sequence finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule